// File: doc/BRIEF.md
# Prioritized Interrupt Request Arbiter

This block collects eight interrupt request lines, holds each pending request in a latch, and drives a single interrupt line toward the processor. Software loads a per-line mask, a trigger mode (edge or level) and a priority mode (fixed or rotating) through a small register-write port: a data byte, a write strobe and a two-bit select. The same port carries the non-specific end-of-interrupt command.

Arbitration runs every cycle over the unmasked pending lines and ranks them against the highest-priority line already in service. A request is offered to the processor only when it outranks everything in service. The offer is tracked by a two-state machine: `ST_IDLE` moves to `ST_ASSERT` on the transition named TR_OFFER (a valid winner exists). `ST_ASSERT` returns to `ST_IDLE` on TR_ACK, when the processor acknowledges and the in-service bit of the winner is set. It also returns on TR_WITHDRAW, when the winner disappears before any acknowledge. In every other case each state holds. In rotating mode each end-of-interrupt makes the line it retires the lowest priority.

Top module: `irq_arbiter`

## Requirements
- R1: A synchronous active-high reset clears the pending and in-service vectors, sets every mask bit, and selects fixed priority with edge triggering. `int_out` stays low afterwards even when a line rises.
- R2: A line whose mask bit is 1 never becomes pending and never produces an interrupt. Unmasked lines on the same cycle are still arbitrated.
- R3: In edge mode a line becomes pending on a 0-to-1 transition of its input. The acknowledge clears that pending bit. An input held high does not make the line pending again.
- R4: In level mode each pending bit equals the input of the previous cycle ANDed with the inverted mask bit.
- R5: In fixed priority, line 0 ranks highest and line 7 lowest. `win_id` names the best-ranked unmasked pending line.
- R6: `int_out` rises on the clock edge after a valid winner first appears. It falls on the edge after an acknowledge, or on the edge after the winner disappears.
- R7: An acknowledge while `int_out` is high and a winner exists sets the winner's in-service bit. An acknowledge while `int_out` is low is ignored.
- R8: A pending line that does not outrank the highest-priority in-service line raises no interrupt. A pending line that outranks it does raise one (nesting).
- R9: The end-of-interrupt command clears exactly one in-service bit: the one with the highest current priority.
- R10: With rotating priority, after an end-of-interrupt the retired line becomes lowest priority and the next line number up (mod 8) becomes highest. Right after the mode write, line 7 is lowest.
- R11: Write select 0 loads the mask, with bit i masking line i. Select 1 loads the mode: bit 0 set means level mode, and bit 1 set means rotating priority. Select 2 is end-of-interrupt, with its data ignored. Select 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Interrupt request lines, index = line number |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 mask, 1 mode, 2 end-of-interrupt, 3 none |
| wr_data | input | 8 | Write data |
| ack | input | 1 | Processor acknowledge of the offered interrupt |
| int_out | output | 1 | Interrupt to the processor |
| win_id | output | 3 | Line number currently winning arbitration |
| pend_out | output | 8 | Pending request vector |
| insvc_out | output | 8 | In-service vector |

## Verification
A wrong mask, mode or rotation pointer shows up as a wrong `win_id`, or as `int_out` staying low when it should rise. The error is visible two edges after the stimulating input change: one edge to latch the request and one to enter `ST_ASSERT`. A corrupted in-service vector shows directly on `insvc_out` one edge after the acknowledge or end-of-interrupt. It also shows indirectly when a nested request is wrongly blocked or wrongly let through. Retriggering faults in edge mode appear as a pending bit that comes back while the input is held high.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;
    localparam int LINES = 8;

    typedef enum logic {
        ST_IDLE,
        ST_ASSERT
    } arb_state_t;

    localparam logic [1:0] SEL_MASK = 2'd0;
    localparam logic [1:0] SEL_MODE = 2'd1;
    localparam logic [1:0] SEL_EOI  = 2'd2;
endpackage

// File: rtl/prio_pick.sv
// Finds the best-ranked set bit of vec; rank 0 is the line just after ptr.
module prio_pick #(
    parameter int N = 8,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] vec,
    input  logic [W-1:0] ptr,
    output logic         any,
    output logic [W-1:0] idx,
    output logic [W-1:0] rank
);
    logic [W-1:0] cand;

    always_comb begin
        any  = 1'b0;
        idx  = '0;
        rank = '1;
        cand = '0;
        for (int r = N - 1; r >= 0; r--) begin
            cand = ptr + W'(1) + W'(r);
            if (vec[cand]) begin
                any  = 1'b1;
                idx  = cand;
                rank = W'(r);
            end
        end
    end
endmodule

// File: rtl/req_latch.sv
module req_latch #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] irq,
    input  logic [N-1:0] mask,
    input  logic         level_mode,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] pend_q
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            pend_q <= '0;
        end else begin
            prev_q <= irq;
            if (level_mode)
                pend_q <= irq & ~mask;
            else
                pend_q <= ((pend_q & ~clr_vec) | (irq & ~prev_q)) & ~mask;
        end
    end

    // R2
    mask_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q & $past(mask)) == '0);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irqarb_pkg::*;
#(
    parameter int N_LINES = LINES,
    localparam int W = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] irq_in,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [N_LINES-1:0] wr_data,
    input  logic               ack,
    output logic               int_out,
    output logic [W-1:0]       win_id,
    output logic [N_LINES-1:0] pend_out,
    output logic [N_LINES-1:0] insvc_out
);
    arb_state_t         state_q, state_n;
    logic [N_LINES-1:0] mask_q, isr_q, pend_q, clr_vec;
    logic               level_q, rotate_q;
    logic [W-1:0]       ptr_q, eff_ptr;
    logic               p_any, s_any, win_valid, do_ack;
    logic [W-1:0]       p_idx, p_rank, s_idx, s_rank;
    logic               wr_mask, wr_mode, wr_eoi;

    assign wr_mask = wr_en && (wr_sel == SEL_MASK);
    assign wr_mode = wr_en && (wr_sel == SEL_MODE);
    assign wr_eoi  = wr_en && (wr_sel == SEL_EOI);
    assign eff_ptr = rotate_q ? ptr_q : W'(N_LINES - 1);

    req_latch #(.N(N_LINES)) u_latch (
        .clk(clk), .rst(rst), .irq(irq_in), .mask(mask_q),
        .level_mode(level_q), .clr_vec(clr_vec), .pend_q(pend_q)
    );

    prio_pick #(.N(N_LINES)) u_pend_pick (
        .vec(pend_q & ~mask_q), .ptr(eff_ptr),
        .any(p_any), .idx(p_idx), .rank(p_rank)
    );

    prio_pick #(.N(N_LINES)) u_svc_pick (
        .vec(isr_q), .ptr(eff_ptr),
        .any(s_any), .idx(s_idx), .rank(s_rank)
    );

    assign win_valid = p_any && (!s_any || (p_rank < s_rank));
    assign do_ack    = ack && (state_q == ST_ASSERT) && win_valid;
    assign clr_vec   = do_ack ? (N_LINES'(1) << p_idx) : '0;

    // Configuration and in-service registers
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q   <= '1;
            level_q  <= 1'b0;
            rotate_q <= 1'b0;
            ptr_q    <= W'(N_LINES - 1);
            isr_q    <= '0;
        end else begin
            if (wr_mask)
                mask_q <= wr_data;
            if (wr_mode) begin
                level_q  <= wr_data[0];
                rotate_q <= wr_data[1];
                ptr_q    <= W'(N_LINES - 1);
            end else if (wr_eoi && s_any && rotate_q) begin
                ptr_q <= s_idx;
            end
            isr_q <= (isr_q & ~((wr_eoi && s_any) ? (N_LINES'(1) << s_idx) : '0))
                     | clr_vec;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_IDLE;
        else
            state_q <= state_n;
    end

    // Transitions: TR_OFFER, TR_ACK, TR_WITHDRAW
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:   if (win_valid) state_n = ST_ASSERT;
            ST_ASSERT: if (do_ack || !win_valid) state_n = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        int_out   = (state_q == ST_ASSERT);
        win_id    = p_idx;
        pend_out  = pend_q;
        insvc_out = isr_q;
    end

    // R6
    int_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(int_out) |-> $past(win_valid));

    // R7
    ack_sets_insvc_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && int_out && win_valid) |=> isr_q[$past(p_idx)]);

    // R8
    nest_rank_chk: assert property (@(posedge clk) disable iff (rst)
        (int_out && win_valid) |-> !isr_q[p_idx]);

    // R9
    eoi_clear_one_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_eoi && s_any && !do_ack) |=>
            ($countones(isr_q) == $countones($past(isr_q)) - 1));
endmodule

// File: tb/irq_arbiter_test.sv
`timescale 1ns/1ps
module irq_arbiter_test;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] irq_in;
    logic       wr_en;
    logic [1:0] wr_sel;
    logic [7:0] wr_data;
    logic       ack;
    logic       int_out;
    logic [2:0] win_id;
    logic [7:0] pend_out, insvc_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    irq_arbiter uut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .ack(ack), .int_out(int_out), .win_id(win_id),
        .pend_out(pend_out), .insvc_out(insvc_out)
    );

    // {irq pattern, expected winner} under fixed priority, level mode
    localparam logic [15:0] VEC [8] = '{
        16'h01_00, 16'h80_07, 16'h81_00, 16'hF0_04,
        16'h0C_02, 16'h60_05, 16'hFE_01, 16'hA0_05
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_ack();
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; irq_in = '0; wr_en = 1'b0; wr_sel = '0; wr_data = '0; ack = 1'b0;
        wait_n(3);
        rst = 1'b0;
        wait_n(1);
        // R1 reset state
        chk(pend_out == 8'h00, "R1 pend", pend_out, 0);
        chk(insvc_out == 8'h00, "R1 insvc", insvc_out, 0);
        chk(int_out == 1'b0, "R1 int", int_out, 0);
        irq_in = 8'h01;
        wait_n(3);
        chk(int_out == 1'b0, "R1 masked after reset", int_out, 0);
        chk(pend_out == 8'h00, "R2 masked not pending", pend_out, 0);
        irq_in = 8'h00;

        // Table: fixed priority, level mode (R5, R4, R6, R11)
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h01);
        wait_n(2);
        for (int i = 0; i < 8; i++) begin
            irq_in = VEC[i][15:8];
            wait_n(2);
            chk(int_out == 1'b1, "R6 int rises", int_out, 1);
            chk(win_id == VEC[i][2:0], "R5 winner", win_id, VEC[i][2:0]);
            chk(pend_out == VEC[i][15:8], "R4 level pend", pend_out, VEC[i][15:8]);
            irq_in = 8'h00;
            wait_n(3);
            chk(int_out == 1'b0, "R4 level release", int_out, 0);
        end

        // R2 partial mask
        wr(2'd0, 8'h01);
        irq_in = 8'h03;
        wait_n(2);
        chk(win_id == 3'd1, "R2 mask winner", win_id, 1);
        chk(pend_out == 8'h02, "R2 mask pend", pend_out, 2);
        irq_in = 8'h00;
        wait_n(3);

        // Edge mode (R3, R7)
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h00);
        irq_in = 8'h04;
        wait_n(2);
        chk(int_out && win_id == 3'd2, "R3 edge offer", {int_out, win_id}, 4'hA);
        pulse_ack();
        chk(insvc_out == 8'h04, "R7 insvc set", insvc_out, 4);
        chk(pend_out == 8'h00, "R3 ack clears pend", pend_out, 0);
        chk(int_out == 1'b0, "R6 int falls on ack", int_out, 0);
        wait_n(3);
        chk(pend_out == 8'h00, "R3 no retrigger", pend_out, 0);

        // Nesting (R8)
        irq_in = 8'h0C;
        wait_n(3);
        chk(int_out == 1'b0, "R8 lower blocked", int_out, 0);
        chk(pend_out == 8'h08, "R3 edge latch", pend_out, 8);
        irq_in = 8'h0E;
        wait_n(2);
        chk(int_out && win_id == 3'd1, "R8 higher nests", {int_out, win_id}, 4'h9);
        pulse_ack();
        chk(insvc_out == 8'h06, "R7 nested insvc", insvc_out, 6);

        // EOI (R9)
        wr(2'd2, 8'h5A);
        chk(insvc_out == 8'h04, "R9 eoi highest", insvc_out, 4);
        wait_n(1);
        chk(int_out == 1'b0, "R8 still blocked", int_out, 0);
        wr(2'd2, 8'h00);
        chk(insvc_out == 8'h00, "R9 eoi second", insvc_out, 0);
        wait_n(1);
        chk(int_out && win_id == 3'd3, "R8 unblocked", {int_out, win_id}, 4'hB);
        pulse_ack();
        wr(2'd2, 8'h00);
        irq_in = 8'h00;
        wait_n(2);

        // Rotating priority (R10)
        wr(2'd1, 8'h02);
        irq_in = 8'h20;
        wait_n(2);
        chk(int_out && win_id == 3'd5, "R10 first", {int_out, win_id}, 4'hD);
        pulse_ack();
        wr(2'd2, 8'h00);
        irq_in = 8'h61;
        wait_n(2);
        chk(int_out && win_id == 3'd6, "R10 rotated winner", {int_out, win_id}, 4'hE);
        pulse_ack();
        chk(insvc_out == 8'h40, "R7 rotate insvc", insvc_out, 8'h40);
        wr(2'd2, 8'h00);
        wait_n(1);
        chk(int_out && win_id == 3'd0, "R10 next winner", {int_out, win_id}, 4'h8);
        pulse_ack();
        wr(2'd2, 8'h00);
        irq_in = 8'h00;
        wait_n(2);

        // R11 select 3 ignored
        wr(2'd3, 8'hFF);
        irq_in = 8'h02;
        wait_n(2);
        chk(int_out && win_id == 3'd1, "R11 sel3 ignored", {int_out, win_id}, 4'h9);
        pulse_ack();
        wr(2'd2, 8'h00);
        irq_in = 8'h00;
        wait_n(2);

        // R7 ack while idle
        pulse_ack();
        wait_n(1);
        chk(insvc_out == 8'h00, "R7 idle ack ignored", insvc_out, 0);

        // R6 withdrawal in level mode
        wr(2'd1, 8'h01);
        irq_in = 8'h10;
        wait_n(2);
        chk(int_out == 1'b1, "R6 level offer", int_out, 1);
        irq_in = 8'h00;
        wait_n(2);
        chk(int_out == 1'b0, "R6 withdraw", int_out, 0);
        chk(insvc_out == 8'h00, "R6 no insvc", insvc_out, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule